// File: doc/BRIEF.md
# Programmable-Field Digit-Serial GF(2^m) Multiplier

This block computes the product of two elements of a binary extension field GF(2^M). The field is not fixed in hardware. The caller supplies the low M coefficients of the reduction polynomial f(x) = x^M + P(x) with every operation, so a single instance can switch fields from one product to the next.

The caller loads the two operands and the polynomial through one narrow W-bit word port over several cycles. Once the last word is in, the datapath consumes operand B one D-bit digit per cycle, starting with the least significant digit. Each cycle it multiplies the running multiple of A by that digit and reduces the result modulo f.

The product port is held at zero by an AND array. It shows the result only in the single cycle in which `done` is high, so the wide output bus toggles only when a result is delivered.

Top module: `gf_dsmul`

## Requirements
- R1: A synchronous reset, active high, clears every register. In the cycle after a reset edge, `done` is 0 and `prod` is all zeros.
- R2: A load takes ceil(M/W) accepted words for each of three items, in this fixed order: A, then B, then P. Within each item the least significant word comes first, and word k carries coefficient bits [k*W+W-1 : k*W]. A word is accepted on a clock edge where `load_valid` is 1. Idle cycles with `load_valid` at 0 may appear between words. Bits of the last word of an item at positions of M and above are ignored.
- R3: The result equals A(x)·B(x) mod (x^M + P(x)) for any M-bit A, B and P, including a polynomial P that makes f reducible.
- R4: `done` goes high for exactly one cycle. It rises on the ceil(M/D)-th clock edge after the edge that accepted the final P word.
- R5: `prod` is all zeros in every cycle in which `done` is 0.
- R6: While a product is being computed, `load_valid` is ignored. Words presented during that time are not stored and do not advance the load sequence, so the next operation still needs a complete fresh load.
- R7: A reset during a computation abandons it. No `done` pulse follows for that operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| load_valid | input | 1 | Marks `load_word` as a word to accept |
| load_word | input | W | Load data word |
| done | output | 1 | One-cycle pulse marking a valid product |
| prod | output | M | Product coefficients, zero outside `done` |

## Verification
The bench builds the block with M = 163, D = 8 and W = 32. With these values, 6 words are loaded per item and each product takes 21 iterations. Neither M/W nor M/D divides evenly, so the padded top bits of the last load word and the partially filled last digit of B are both exercised. Because M is a real cryptographic field size, the bench can cover the standard pentanomial alongside random, sparse, all-ones and reducible polynomials, with gapped loads and load noise during computation.

// File: rtl/gf_dsmul_pkg.sv
package gf_dsmul_pkg;

  typedef enum logic {
    ST_LOAD = 1'b0,
    ST_RUN  = 1'b1
  } state_t;

  typedef enum logic [1:0] {
    PH_A = 2'd0,
    PH_B = 2'd1,
    PH_P = 2'd2
  } phase_t;

  function automatic int cdiv(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int cw(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/gf_dsmul_loader.sv
module gf_dsmul_loader
  import gf_dsmul_pkg::*;
#(
  parameter int M = 163,
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         accept,
  input  logic [W-1:0] word,
  output logic [M-1:0] a_full,
  output logic [M-1:0] b_full,
  output logic [M-1:0] p_full,
  output logic         last_word
);

  localparam int NW  = cdiv(M, W);
  localparam int WIW = cw(NW);
  localparam int PW  = NW * W;

  phase_t             ph;
  logic [WIW-1:0]     widx;
  logic [2:0][M-1:0]  items;
  logic               item_end;

  assign item_end  = (widx == WIW'(NW - 1));
  assign last_word = accept && (ph == PH_P) && item_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph   <= PH_A;
      widx <= '0;
    end else if (accept) begin
      if (item_end) begin
        widx <= '0;
        case (ph)
          PH_A:    ph <= PH_B;
          PH_B:    ph <= PH_P;
          default: ph <= PH_A;
        endcase
      end else begin
        widx <= widx + 1'b1;
      end
    end
  end

  for (genvar g = 0; g < 3; g++) begin : g_item
    logic [PW-1:0] store;
    always_ff @(posedge clk) begin
      if (rst) begin
        store <= '0;
      end else if (accept && (ph == phase_t'(g))) begin
        store[widx*W +: W] <= word;
      end
    end
    assign items[g] = store[M-1:0];
  end

  assign a_full = items[0];
  assign b_full = items[1];
  assign p_full = items[2];

endmodule

// File: rtl/gf_dsmul_digit_sel.sv
module gf_dsmul_digit_sel
  import gf_dsmul_pkg::*;
#(
  parameter int M = 163,
  parameter int D = 8
) (
  input  logic [M-1:0]          b_full,
  input  logic [cw(cdiv(M,D))-1:0] idx,
  output logic [D-1:0]          digit
);

  localparam int ND = cdiv(M, D);
  localparam int BW = ND * D;

  logic [BW-1:0] b_pad;

  always_comb begin
    b_pad         = '0;
    b_pad[M-1:0]  = b_full;
  end

  assign digit = b_pad[idx*D +: D];

endmodule

// File: rtl/gf_dsmul_step.sv
module gf_dsmul_step #(
  parameter int M = 163,
  parameter int D = 8
) (
  input  logic [M-1:0] a_in,
  input  logic [M-1:0] c_in,
  input  logic [M-1:0] poly,
  input  logic [D-1:0] digit,
  output logic [M-1:0] a_out,
  output logic [M-1:0] c_out
);

  always_comb begin
    logic [M-1:0] t;
    logic [M-1:0] acc;
    t   = a_in;
    acc = c_in;
    for (int j = 0; j < D; j++) begin
      if (digit[j]) acc = acc ^ t;
      t = {t[M-2:0], 1'b0} ^ (t[M-1] ? poly : '0);
    end
    a_out = t;
    c_out = acc;
  end

endmodule

// File: rtl/gf_dsmul_out_gate.sv
module gf_dsmul_out_gate #(
  parameter int M = 163
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         fire,
  input  logic [M-1:0] value,
  output logic         done_q,
  output logic [M-1:0] prod_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q <= 1'b0;
      prod_q <= '0;
    end else begin
      done_q <= fire;
      prod_q <= value & {M{fire}};
    end
  end

endmodule

// File: rtl/gf_dsmul.sv
module gf_dsmul
  import gf_dsmul_pkg::*;
#(
  parameter int M = 163,
  parameter int D = 8,
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_valid,
  input  logic [W-1:0] load_word,
  output logic         done,
  output logic [M-1:0] prod
);

  localparam int ND  = cdiv(M, D);
  localparam int DIW = cw(ND);

  state_t          st;
  logic [DIW-1:0]  idx;
  logic [M-1:0]    a_full, b_full, p_full;
  logic [M-1:0]    a_work, c_acc, a_nxt, c_nxt;
  logic [D-1:0]    digit;
  logic            busy, accept, load_last, fire;

  assign busy   = (st == ST_RUN);
  assign accept = load_valid && !busy;
  assign fire   = busy && (idx == DIW'(ND - 1));

  gf_dsmul_loader #(.M(M), .W(W)) u_loader (
    .clk       (clk),
    .rst       (rst),
    .accept    (accept),
    .word      (load_word),
    .a_full    (a_full),
    .b_full    (b_full),
    .p_full    (p_full),
    .last_word (load_last)
  );

  gf_dsmul_digit_sel #(.M(M), .D(D)) u_digit (
    .b_full (b_full),
    .idx    (idx),
    .digit  (digit)
  );

  gf_dsmul_step #(.M(M), .D(D)) u_step (
    .a_in  (a_work),
    .c_in  (c_acc),
    .poly  (p_full),
    .digit (digit),
    .a_out (a_nxt),
    .c_out (c_nxt)
  );

  gf_dsmul_out_gate #(.M(M)) u_gate (
    .clk    (clk),
    .rst    (rst),
    .fire   (fire),
    .value  (c_nxt),
    .done_q (done),
    .prod_q (prod)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_LOAD;
      idx    <= '0;
      a_work <= '0;
      c_acc  <= '0;
    end else begin
      case (st)
        ST_LOAD: begin
          if (load_last) begin
            st     <= ST_RUN;
            idx    <= '0;
            a_work <= a_full;
            c_acc  <= '0;
          end
        end
        default: begin
          a_work <= a_nxt;
          c_acc  <= c_nxt;
          idx    <= idx + 1'b1;
          if (fire) st <= ST_LOAD;
        end
      endcase
    end
  end

endmodule

// File: rtl/gf_dsmul_chk.sv
module gf_dsmul_chk #(
  parameter int M = 163
) (
  input logic         clk,
  input logic         rst,
  input logic         busy,
  input logic [M-1:0] p_full,
  input logic         done,
  input logic [M-1:0] prod
);

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!done && (prod == '0)));                                   // R1

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);                                                    // R4

  AST_DONE_FROM_RUN: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(busy));                                              // R4

  AST_OUT_GATED: assert property (@(posedge clk) disable iff (rst)
    !done |-> (prod == '0));                                            // R5

  AST_FIELD_HELD: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(p_full));                                          // R6

endmodule

bind gf_dsmul gf_dsmul_chk #(.M(M)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .busy   (busy),
  .p_full (p_full),
  .done   (done),
  .prod   (prod)
);

// File: tb/gf_dsmul_bench.sv
module gf_dsmul_bench;

  localparam int M  = 163;
  localparam int D  = 8;
  localparam int W  = 32;
  localparam int NW = (M + W - 1) / W;
  localparam int ND = (M + D - 1) / D;
  localparam int PW = NW * W;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         load_valid = 1'b0;
  logic [W-1:0] load_word = '0;
  logic         done;
  logic [M-1:0] prod;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  gf_dsmul #(.M(M), .D(D), .W(W)) u_gf_dsmul (
    .clk        (clk),
    .rst        (rst),
    .load_valid (load_valid),
    .load_word  (load_word),
    .done       (done),
    .prod       (prod)
  );

  function automatic logic [M-1:0] ref_mul(input logic [M-1:0] a,
                                           input logic [M-1:0] b,
                                           input logic [M-1:0] p);
    logic [M-1:0] r;
    logic         hi;
    r = '0;
    for (int i = M - 1; i >= 0; i--) begin
      hi = r[M-1];
      r  = r << 1;
      if (hi) r = r ^ p;
      if (b[i]) r = r ^ a;
    end
    return r;
  endfunction

  function automatic logic [PW-1:0] rnd_pad();
    logic [PW-1:0] v;
    for (int k = 0; k < NW; k++) v[k*W +: W] = $urandom;
    return v;
  endfunction

  function automatic logic [M-1:0] rnd_m();
    logic [PW-1:0] v;
    v = rnd_pad();
    return v[M-1:0];
  endfunction

  task automatic check(input bit ok, input string tag,
                       input logic [M-1:0] act, input logic [M-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // R2: words LS first, A then B then P; junk above bit M-1, optional gaps
  task automatic send(input logic [M-1:0] a, input logic [M-1:0] b,
                      input logic [M-1:0] p, input bit gaps);
    logic [PW-1:0] buf3 [3];
    buf3[0] = rnd_pad(); buf3[0][M-1:0] = a;
    buf3[1] = rnd_pad(); buf3[1][M-1:0] = b;
    buf3[2] = rnd_pad(); buf3[2][M-1:0] = p;
    for (int op = 0; op < 3; op++) begin
      for (int k = 0; k < NW; k++) begin
        if (gaps && ($urandom % 3 == 0)) begin
          @(negedge clk);
          load_valid = 1'b0;
          load_word  = $urandom;
        end
        @(negedge clk);
        load_valid = 1'b1;
        load_word  = buf3[op][k*W +: W];
      end
    end
  endtask

  // R4/R5/R6: sample every negedge after the final load edge
  task automatic collect(input logic [M-1:0] exp, input bit noisy);
    for (int k = 1; k <= ND + 2; k++) begin
      @(negedge clk);
      load_valid = noisy && (k <= ND);
      load_word  = $urandom;
      if (k <= ND) begin
        check(!done, "R4 early done", M'(done), '0);
        check(prod == '0, "R5 output not gated", prod, '0);
      end else if (k == ND + 1) begin
        check(done, "R4 done latency", M'(done), M'(1));
        check(prod == exp, noisy ? "R3/R6 product" : "R3 product", prod, exp);
      end else begin
        check(!done, "R4 done width", M'(done), '0);
        check(prod == '0, "R5 output after done", prod, '0);
      end
    end
    load_valid = 1'b0;
  endtask

  task automatic run_op(input logic [M-1:0] a, input logic [M-1:0] b,
                        input logic [M-1:0] p, input bit gaps, input bit noisy);
    send(a, b, p, gaps);
    collect(ref_mul(a, b, p), noisy);
  endtask

  initial begin
    logic [M-1:0] polys [5];
    logic [M-1:0] a, b, x162;
    void'($urandom(32'h5eed_0163));
    polys[0] = '0; polys[0][7] = 1'b1; polys[0][6] = 1'b1;
    polys[0][3] = 1'b1; polys[0][0] = 1'b1;
    polys[1] = M'(1);
    polys[2] = '1;
    polys[3] = rnd_m();
    polys[4] = rnd_m();
    x162 = '0; x162[M-1] = 1'b1;

    repeat (3) @(negedge clk);
    check(!done, "R1 reset done", M'(done), '0);
    check(prod == '0, "R1 reset prod", prod, '0);
    rst = 1'b0;

    a = rnd_m();
    run_op('0, a, polys[0], 1'b0, 1'b0);            // R3 zero operand
    run_op(a, M'(1), polys[0], 1'b0, 1'b0);         // R3 identity
    run_op(M'(1), x162, polys[0], 1'b1, 1'b0);      // R3 top coefficient
    run_op('1, '1, polys[2], 1'b0, 1'b0);           // R3 dense
    run_op(x162, x162, '0, 1'b0, 1'b0);             // R3 reducible field x^M
    run_op(rnd_m(), rnd_m(), polys[1], 1'b1, 1'b1); // R6 noise while busy

    // R7: reset in the middle of a computation
    send(rnd_m(), rnd_m(), polys[0], 1'b0);
    repeat (5) @(negedge clk);
    load_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(!done && prod == '0, "R1 reset mid-run", prod, '0);
    for (int k = 0; k < ND + 3; k++) begin
      @(negedge clk);
      check(!done, "R7 abandoned op done", M'(done), '0);
    end

    for (int n = 0; n < 40; n++) begin
      a = rnd_m();
      b = rnd_m();
      run_op(a, b, polys[n % 5], n[0], (n % 3) == 0);  // R2 R3 R6
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule